// File: doc/BRIEF.md
# Flash Write-Mode Unlock Sequencer

This block tracks CPU writes to an on-chip flash and decides when the flash may leave normal read mode and accept program operations. It sees every bus write (strobe, address and data) and follows a fixed order: the unlock key goes to the control register, then the same key goes to the array location whose address equals the key. Only that pair opens writing mode. After opening, a settle counter gives the charge pump time before program operations count as valid.

Inside writing mode the sequencer also runs the one-time programming of the protection enable fuse. The setup word goes to the control register twice in a row, the first write being a dummy. Then a secondary control word with bits 14 and 10 set starts a fuse program pulse of fixed length. The pulse is issued only when the device is in test mode and the programming voltage is present. Writing zero to the control register leaves writing mode. Any write that breaks the expected order sends the sequencer back to idle, and the unlock has to start over. The settle and pulse lengths are parameters counted in clock cycles.

Top module: `flash_wrmode_seq`

## Requirements
- R1: After reset, wm_active, hv_ready and fuse_pgm are 0 and reg_rd is 0x0000.
- R2: A write of KEY (default 0x4000) to CTRL_ADDR (default 0x7FFE), followed by a write of KEY to address KEY as the very next write, raises wm_active on the clock edge that takes the second write.
- R3: If the write after the first unlock step is not KEY to address KEY (wrong address or wrong data), the sequencer returns to idle, and a following lone KEY-to-KEY write does not open writing mode.
- R4: hv_ready rises exactly SETTLE_CYC clock cycles after wm_active rises.
- R5: Any write while the settle period is running drops wm_active to 0 on the edge that takes the write.
- R6: reg_rd reads 0x0010 (bit 4 set, all other bits 0) while wm_active and vpp_ok are both 1, and 0x0000 otherwise.
- R7: After settle, SETUP (default 0x8081) written twice in a row to CTRL_ADDR, then a word with bits 14 and 10 set written to SEC_ADDR (default 0x7FFC), with test_mode and vpp_ok both 1, makes fuse_pgm 1 for exactly PULSE_CYC cycles, starting on the edge that takes that word. Afterwards wm_active and hv_ready stay 1.
- R8: If SETUP is written only once and the next write is not the second SETUP, the sequencer returns to idle (wm_active 0) and no pulse is issued.
- R9: If test_mode or vpp_ok is 0 when the secondary word is written, no pulse is issued and writing mode stays open.
- R10: A write of 0x0000 to CTRL_ADDR after settle drops wm_active and hv_ready to 0 on the next edge.
- R11: Writes while fuse_pgm is 1 are ignored. The pulse still runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| vpp_ok | input | 1 | Programming voltage present |
| test_mode | input | 1 | Device is in test mode |
| wm_active | output | 1 | Writing mode open |
| hv_ready | output | 1 | Settle period over, program operations valid |
| fuse_pgm | output | 1 | Fuse program pulse |
| reg_rd | output | DW | Control register read value |

## Verification
The bench breaks the unlock pair in several ways: wrong address, wrong data, and a second step sent alone afterwards. A sequencer that kept partial progress would open writing mode on the lone step. It samples hv_ready one cycle before and at the settle limit, so an off-by-one counter shows up. It also writes during settle, which a sequencer without that abort would let through. On the fuse path it sends a single setup word, and it also drops test mode and then the voltage. A design that skipped the dummy write or ignored those gates would pulse the fuse. It counts the pulse length while writing during the pulse, so a pulse that is cut short or retriggered would give the wrong count.

// File: rtl/flash_wrmode_seq.sv
module flash_wrmode_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h7FFE,
  parameter logic [AW-1:0] SEC_ADDR  = 16'h7FFC,
  parameter logic [DW-1:0] KEY       = 16'h4000,
  parameter logic [DW-1:0] SETUP     = 16'h8081,
  parameter int SETTLE_CYC = 1250,
  parameter int PULSE_CYC  = 125000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          vpp_ok,
  input  logic          test_mode,
  output logic          wm_active,
  output logic          hv_ready,
  output logic          fuse_pgm,
  output logic [DW-1:0] reg_rd
);
  localparam int MAXC = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETTLE, S_OPEN, S_SU1, S_SU2, S_PROG} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  wire ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  wire key_hit = wr_en && (wr_addr == AW'(KEY)) && (wr_data == KEY);
  wire su_hit  = ctrl_wr && (wr_data == SETUP);
  wire sec_hit = wr_en && (wr_addr == SEC_ADDR) && wr_data[14] && wr_data[10];
  wire cnt_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctrl_wr && wr_data == KEY) st <= S_ARM;
        S_ARM: if (wr_en) begin
          if (key_hit) begin
            st  <= S_SETTLE;
            cnt <= CW'(SETTLE_CYC - 1);
          end else st <= S_IDLE;
        end
        S_SETTLE: begin
          if (wr_en) st <= S_IDLE;
          else if (cnt_end) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_OPEN: if (ctrl_wr) begin
          if (wr_data == '0) st <= S_IDLE;
          else if (wr_data == SETUP) st <= S_SU1;
        end
        S_SU1: if (wr_en) st <= su_hit ? S_SU2 : S_IDLE;
        S_SU2: if (wr_en) begin
          if (!sec_hit) st <= S_IDLE;
          else if (test_mode && vpp_ok) begin
            st  <= S_PROG;
            cnt <= CW'(PULSE_CYC - 1);
          end else st <= S_OPEN;
        end
        S_PROG: begin
          if (cnt_end) st <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wm_active = (st != S_IDLE) && (st != S_ARM);
  assign hv_ready  = wm_active && (st != S_SETTLE);
  assign fuse_pgm  = (st == S_PROG);
  assign reg_rd    = DW'({wm_active && vpp_ok, 4'b0000});
endmodule

// File: rtl/flash_wrmode_seq_sva.sv
module flash_wrmode_seq_sva #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h7FFE,
  parameter logic [DW-1:0] KEY = 16'h4000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          vpp_ok,
  input logic          test_mode,
  input logic          wm_active,
  input logic          hv_ready,
  input logic          fuse_pgm,
  input logic [DW-1:0] reg_rd
);
  a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wm_active) |-> $past(wr_en && wr_addr == AW'(KEY) && wr_data == KEY));
  a_r4_ready_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_ready) |-> $past(wm_active && !hv_ready));
  a_r4_ready_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    hv_ready |-> wm_active);
  a_r6_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_active |-> reg_rd == '0);
  a_r9_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_pgm) |-> $past(test_mode && vpp_ok));
  a_r7_pulse_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_pgm |-> hv_ready);
  a_r10_exit_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wm_active) |-> $past(wr_en));
endmodule

bind flash_wrmode_seq flash_wrmode_seq_sva #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .KEY(KEY)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .vpp_ok(vpp_ok), .test_mode(test_mode), .wm_active(wm_active), .hv_ready(hv_ready),
  .fuse_pgm(fuse_pgm), .reg_rd(reg_rd));

// File: tb/flash_wrmode_seq_tb.sv
module flash_wrmode_seq_tb;
  localparam logic [15:0] CA = 16'h7FFE, SA = 16'h7FFC, KY = 16'h4000, SU = 16'h8081;
  localparam int ST = 5, PL = 7;

  logic clk = 0, rst_n = 0, wr_en = 0, vpp_ok = 1, test_mode = 1;
  logic [15:0] wr_addr = 0, wr_data = 0, reg_rd;
  logic wm_active, hv_ready, fuse_pgm;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_wrmode_seq #(.SETTLE_CYC(ST), .PULSE_CYC(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .test_mode(test_mode), .wm_active(wm_active), .hv_ready(hv_ready),
    .fuse_pgm(fuse_pgm), .reg_rd(reg_rd));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic unlock();
    wr(CA, KY); wr(KY, KY);
    repeat (ST) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wm", wm_active, 0); chk("R1 hv", hv_ready, 0);
    chk("R1 pgm", fuse_pgm, 0); chk("R1 rd", reg_rd, 16'h0000);
  endtask

  task automatic t_unlock();
    wr(CA, KY); chk("R2 one step", wm_active, 0);
    wr(KY, KY); chk("R2 open", wm_active, 1);
    repeat (ST - 1) @(negedge clk); chk("R4 before", hv_ready, 0);
    @(negedge clk); chk("R4 at limit", hv_ready, 1);
    chk("R6 rd vpp", reg_rd, 16'h0010);
    vpp_ok = 0; #1 chk("R6 rd novpp", reg_rd, 16'h0000); vpp_ok = 1;
    wr(CA, 16'h0000); chk("R10 exit wm", wm_active, 0); chk("R10 exit hv", hv_ready, 0);
  endtask

  task automatic t_break();
    wr(CA, KY); wr(16'h4002, KY); chk("R3 bad addr", wm_active, 0);
    wr(KY, KY); chk("R3 lone step", wm_active, 0);
    wr(CA, KY); wr(KY, 16'h4001); chk("R3 bad data", wm_active, 0);
  endtask

  task automatic t_settle_abort();
    wr(CA, KY); wr(KY, KY);
    wr(16'h0100, 16'h1234); chk("R5 abort", wm_active, 0);
    repeat (ST + 2) @(negedge clk); chk("R5 stays idle", hv_ready, 0);
  endtask

  task automatic t_fuse();
    int n = 0;
    unlock();
    wr(CA, SU); wr(CA, SU); wr(SA, 16'h4400);
    while (fuse_pgm && n < 100) begin
      n++;
      if (n == 2) begin wr_en = 1; wr_addr = CA; wr_data = 16'h0000; end
      if (n == 3) wr_en = 0;
      @(negedge clk);
    end
    chk("R7 pulse len", 16'(n), 16'(PL));
    chk("R11 mode kept", wm_active, 1); chk("R7 hv kept", hv_ready, 1);
    wr(CA, 0);
  endtask

  task automatic t_single_setup();
    unlock();
    wr(CA, SU); wr(SA, 16'h4400);
    chk("R8 idle", wm_active, 0); chk("R8 no pulse", fuse_pgm, 0);
  endtask

  task automatic t_gated(logic tm, logic vp, string req);
    unlock();
    test_mode = tm; vpp_ok = vp;
    wr(CA, SU); wr(CA, SU); wr(SA, 16'h4400);
    chk(req, fuse_pgm, 0);
    @(negedge clk); chk(req, fuse_pgm, 0); chk(req, hv_ready, 1);
    test_mode = 1; vpp_ok = 1;
    wr(CA, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_unlock();
    t_break();
    t_settle_abort();
    t_fuse();
    t_single_setup();
    t_gated(0, 1, "R9 no test mode");
    t_gated(1, 0, "R9 no vpp");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule